// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a memory-mapped master for the two-wire management bus that connects a MAC to Ethernet PHYs. Software sets up a clock divider, a frame style (Clause 22 or Clause 45) and a preamble option in a configuration word. It loads 16-bit data into a data word and then writes a command word that holds an opcode, a PHY address and a register (or device) address. The block then serialises a complete frame on MDIO, timed by an MDC clock it derives from the system clock.

On a read frame the master releases MDIO from the turnaround onward. It checks that the PHY pulls the second turnaround bit low and shifts in the 16 data bits. Completion is reported through two separate busy flags: one in the write-data word for address and write frames, and one in the read-data word for reads. The read-data word also carries a flag that marks the captured data as good. A master enable word starts and stops the bus. Clearing it stops MDC and releases MDIO at once.

The CSR port has separate write and read addresses, and the read side is combinational. Each word is 64 bits wide and sits at a byte offset that is a multiple of 8.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, reading offset 0x18 returns 0x1004 (half-period field = 4 in bits [7:0], preamble bit 12 set, style bit 24 clear) and offsets 0x20, 0x08 and 0x00 return 0. Writes to 0x18, 0x20 (bit 0) and 0x08 (bits [15:0]) read back unchanged.
- R2: While enabled, each high phase and each low phase of MDC lasts (half-period field + 1) system clocks. While disabled, MDC is held low and MDIO is not driven.
- R3: In Clause 22 style (bit 24 = 0), a command written to 0x00 with opcode 0 in bits [1:0], PHY address in [12:8] and register in [20:16] sends, MSB first, 32 ones, start 01, op 01, PHY, register, turnaround 10 and the 16 bits held at 0x08. MDIO changes only when MDC falls.
- R4: In Clause 22 style, opcode 1 sends the same header with op 10, then releases MDIO from the first turnaround bit. The 16 data bits sampled on the rising MDC edges appear MSB first in bits [15:0] of 0x10.
- R5: In Clause 45 style (bit 24 = 1), opcode 0 sends an address frame (start 00, op 00) and opcode 1 sends a write frame (start 00, op 01). Both carry the 16 bits held at 0x08, and the register field carries the device address.
- R6: In Clause 45 style, opcode 3 sends a read frame with start 00 and op 11, and returns the data as in R4.
- R7: With the preamble bit clear, the frame begins directly with the start bits and is 32 bits long.
- R8: Bit 16 of 0x08 reads 1 from the cycle after an address or write command is accepted until the frame ends. Bit 17 of 0x10 does the same for read frames. Both flags fall in the cycle after the last data bit is sampled, and they are never set together.
- R9: Bit 16 of 0x10 (read good) is set at the end of a read only if the PHY held the second turnaround bit low. Any accepted command clears it.
- R10: A command is ignored while either busy flag is set, while the block is disabled, or when the opcode is not defined for the current style (2 or 3 in Clause 22; 2 in Clause 45).
- R11: Clearing bit 0 of 0x20 during a frame aborts it. Two cycles after the write, both busy flags are 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_waddr | input | 6 | CSR write byte offset |
| csr_wdata | input | 64 | CSR write data |
| csr_raddr | input | 6 | CSR read byte offset |
| csr_rdata | output | 64 | CSR read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Two things can fall in the same cycle: a frame finishing, which drops its busy flag, and software writing the next command. The bench starts a write frame and then writes a read command on every cycle while it watches both busy flags. A command that lands while the write flag still reads 1 must be dropped. The first one that lands after the flag reads 0 must start the read at once, with no gap cycle. The read that follows must still return the data the PHY model supplies, with the good flag set.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int CSR_AW     = 6;
  localparam int CSR_DW     = 64;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int POS_W      = 6;
  localparam int DATA_W     = 16;

  localparam logic [CSR_AW-1:0] OFS_CMD   = 6'h00;
  localparam logic [CSR_AW-1:0] OFS_WRDAT = 6'h08;
  localparam logic [CSR_AW-1:0] OFS_RDDAT = 6'h10;
  localparam logic [CSR_AW-1:0] OFS_CFG   = 6'h18;
  localparam logic [CSR_AW-1:0] OFS_EN    = 6'h20;

  localparam int CMD_OPC_LSB  = 0;
  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_REG_LSB  = 16;
  localparam int WR_PEND_BIT  = 16;
  localparam int RD_GOOD_BIT  = 16;
  localparam int RD_PEND_BIT  = 17;
  localparam int CFG_PRE_BIT  = 12;
  localparam int CFG_MODE_BIT = 24;

  localparam logic [POS_W-1:0] POS_PRE_END = POS_W'(PRE_BITS);
  localparam logic [POS_W-1:0] POS_TA1     = POS_W'(46);
  localparam logic [POS_W-1:0] POS_TA2     = POS_W'(47);
  localparam logic [POS_W-1:0] POS_DATA    = POS_W'(48);
  localparam logic [POS_W-1:0] POS_LAST    = POS_W'(FRAME_BITS-1);

  typedef enum logic [1:0] {FR_NONE, FR_ADDR, FR_WRITE, FR_READ} frame_kind_e;

  // Opcode meaning depends on the frame style selected in the config word.
  function automatic frame_kind_e decode_kind(input logic c45, input logic [1:0] opc);
    frame_kind_e k;
    k = FR_NONE;
    if (!c45) begin
      case (opc)
        2'd0:    k = FR_WRITE;
        2'd1:    k = FR_READ;
        default: k = FR_NONE;
      endcase
    end else begin
      case (opc)
        2'd0:    k = FR_ADDR;
        2'd1:    k = FR_WRITE;
        2'd3:    k = FR_READ;
        default: k = FR_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic [1:0] op_field(input logic c45, input frame_kind_e k);
    logic [1:0] op;
    case (k)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      FR_READ:  op = c45 ? 2'b11 : 2'b10;
      default:  op = 2'b00;
    endcase
    return op;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic c45, input frame_kind_e k,
      input logic [4:0] phy, input logic [4:0] rga, input logic [DATA_W-1:0] data);
    logic [1:0] st;
    st = c45 ? 2'b00 : 2'b01;
    return {{PRE_BITS{1'b1}}, st, op_field(c45, k), phy, rga, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  // >= so that lowering the divider mid-phase cannot cause a long wrap
  assign tick     = en && (cnt_q >= half_div);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_parked_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_csr_bank.sv
`timescale 1ns/1ps
module mdio_csr_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic [CSR_AW-1:0]     csr_waddr,
  input  logic [CSR_DW-1:0]     csr_wdata,
  input  logic [CSR_AW-1:0]     csr_raddr,
  output logic [CSR_DW-1:0]     csr_rdata,
  input  logic                  wr_pend,
  input  logic                  rd_pend,
  input  logic                  rd_good,
  input  logic [DATA_W-1:0]     rd_data,
  output logic [DIV_W-1:0]      cfg_div,
  output logic                  cfg_pre,
  output logic                  cfg_c45,
  output logic                  ctl_en,
  output logic                  cmd_fire,
  output logic                  cmd_read,
  output logic [FRAME_BITS-1:0] cmd_frame
);
  logic [DATA_W-1:0] wr_data_q;
  logic [1:0]        opc_q;
  logic [4:0]        phy_q;
  logic [4:0]        rga_q;
  logic [20:0]       cmd_q;
  logic              cmd_hit;
  logic              busy;
  logic [1:0]        w_opc;
  logic [4:0]        w_phy;
  logic [4:0]        w_rga;
  frame_kind_e       w_kind;
  logic              unused_wdata_bits;

  assign w_opc   = csr_wdata[CMD_OPC_LSB +: 2];
  assign w_phy   = csr_wdata[CMD_PHY_LSB +: 5];
  assign w_rga   = csr_wdata[CMD_REG_LSB +: 5];
  assign w_kind  = decode_kind(cfg_c45, w_opc);
  assign busy    = wr_pend || rd_pend;
  assign cmd_hit = csr_we && (csr_waddr == OFS_CMD);

  // named acceptance event: enabled, idle and an opcode defined for the style
  assign cmd_fire  = cmd_hit && ctl_en && !busy && (w_kind != FR_NONE);
  assign cmd_read  = (w_kind == FR_READ);
  assign cmd_frame = build_frame(cfg_c45, w_kind, w_phy, w_rga, wr_data_q);
  assign cmd_q     = {rga_q, 3'b000, phy_q, 6'b000000, opc_q};

  assign unused_wdata_bits = ^{csr_wdata[CSR_DW-1:CFG_MODE_BIT+1],
                               csr_wdata[CFG_MODE_BIT-1:21],
                               csr_wdata[CFG_PRE_BIT-1:DIV_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data_q <= '0;
      opc_q     <= '0;
      phy_q     <= '0;
      rga_q     <= '0;
      cfg_div   <= DIV_W'(DIV_RST);
      cfg_pre   <= 1'b1;
      cfg_c45   <= 1'b0;
      ctl_en    <= 1'b0;
    end else if (csr_we) begin
      if (cmd_fire) begin
        opc_q <= w_opc;
        phy_q <= w_phy;
        rga_q <= w_rga;
      end
      if (csr_waddr == OFS_WRDAT) wr_data_q <= csr_wdata[DATA_W-1:0];
      if (csr_waddr == OFS_CFG) begin
        cfg_div <= csr_wdata[DIV_W-1:0];
        cfg_pre <= csr_wdata[CFG_PRE_BIT];
        cfg_c45 <= csr_wdata[CFG_MODE_BIT];
      end
      if (csr_waddr == OFS_EN) ctl_en <= csr_wdata[0];
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_raddr)
      OFS_CMD: csr_rdata[20:0] = cmd_q;
      OFS_WRDAT: begin
        csr_rdata[DATA_W-1:0]  = wr_data_q;
        csr_rdata[WR_PEND_BIT] = wr_pend;
      end
      OFS_RDDAT: begin
        csr_rdata[DATA_W-1:0]  = rd_data;
        csr_rdata[RD_GOOD_BIT] = rd_good;
        csr_rdata[RD_PEND_BIT] = rd_pend;
      end
      OFS_CFG: begin
        csr_rdata[DIV_W-1:0]    = cfg_div;
        csr_rdata[CFG_PRE_BIT]  = cfg_pre;
        csr_rdata[CFG_MODE_BIT] = cfg_c45;
      end
      OFS_EN:  csr_rdata[0] = ctl_en;
      default: csr_rdata = '0;
    endcase
  end

  assert_cmd_dropped_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && busy) |=> $stable(cmd_q));
  assert_good_cleared_on_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !rd_good);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  pre_en,
  input  logic                  start,
  input  logic                  start_read,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdc,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  wr_pend,
  output logic                  rd_pend,
  output logic                  rd_good,
  output logic [DATA_W-1:0]     rd_data
);
  logic                  active_q;
  logic                  launched_q;
  logic                  read_q;
  logic                  ta_ok_q;
  logic [POS_W-1:0]      pos_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [DATA_W-2:0]     shift_q;
  logic [POS_W-1:0]      next_pos;
  logic [POS_W-1:0]      bit_idx;
  logic                  drive_evt;
  logic                  sample_evt;
  logic                  last_evt;

  // the first falling edge launches the current bit; later ones advance
  assign next_pos   = launched_q ? pos_q + 1'b1 : pos_q;
  assign bit_idx    = POS_LAST - next_pos;
  assign drive_evt  = active_q && fall_evt;
  assign sample_evt = active_q && launched_q && rise_evt;
  assign last_evt   = sample_evt && (pos_q == POS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      launched_q <= 1'b0;
      read_q     <= 1'b0;
      ta_ok_q    <= 1'b0;
      pos_q      <= '0;
      frame_q    <= '0;
      shift_q    <= '0;
      mdio_o     <= 1'b1;
      mdio_oe    <= 1'b0;
      wr_pend    <= 1'b0;
      rd_pend    <= 1'b0;
      rd_good    <= 1'b0;
      rd_data    <= '0;
    end else if (!enable) begin
      active_q   <= 1'b0;
      launched_q <= 1'b0;
      wr_pend    <= 1'b0;
      rd_pend    <= 1'b0;
      mdio_oe    <= 1'b0;
      mdio_o     <= 1'b1;
    end else if (start) begin
      active_q   <= 1'b1;
      launched_q <= 1'b0;
      read_q     <= start_read;
      frame_q    <= start_frame;
      pos_q      <= pre_en ? '0 : POS_PRE_END;
      wr_pend    <= !start_read;
      rd_pend    <= start_read;
      rd_good    <= 1'b0;
      ta_ok_q    <= 1'b0;
    end else begin
      if (drive_evt) begin
        launched_q <= 1'b1;
        pos_q      <= next_pos;
        mdio_o     <= frame_q[bit_idx];
        mdio_oe    <= !(read_q && (next_pos >= POS_TA1));
      end else if (fall_evt) begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b1;
      end
      if (sample_evt) begin
        if (read_q && (pos_q == POS_TA2)) ta_ok_q <= !mdio_i;
        if (read_q && (pos_q >= POS_DATA)) shift_q <= {shift_q[DATA_W-3:0], mdio_i};
      end
      if (last_evt) begin
        active_q   <= 1'b0;
        launched_q <= 1'b0;
        wr_pend    <= 1'b0;
        rd_pend    <= 1'b0;
        if (read_q) begin
          rd_data <= {shift_q, mdio_i};
          rd_good <= ta_ok_q;
        end
      end
    end
  end

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pend && rd_pend));
  assert_abort_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mdio_oe && !wr_pend && !rd_pend));
  assert_mdio_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));
  assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && read_q && launched_q && (pos_q >= POS_TA1)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_waddr,
  input  logic [CSR_DW-1:0] csr_wdata,
  input  logic [CSR_AW-1:0] csr_raddr,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]      cfg_div;
  logic                  cfg_pre;
  logic                  cfg_c45;
  logic                  ctl_en;
  logic                  cmd_fire;
  logic                  cmd_read;
  logic [FRAME_BITS-1:0] cmd_frame;
  logic                  rise_evt;
  logic                  fall_evt;
  logic                  wr_pend;
  logic                  rd_pend;
  logic                  rd_good;
  logic [DATA_W-1:0]     rd_data;

  mdio_csr_bank #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
    .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
    .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_good(rd_good), .rd_data(rd_data),
    .cfg_div(cfg_div), .cfg_pre(cfg_pre), .cfg_c45(cfg_c45), .ctl_en(ctl_en),
    .cmd_fire(cmd_fire), .cmd_read(cmd_read), .cmd_frame(cmd_frame)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .half_div(cfg_div),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .enable(ctl_en), .pre_en(cfg_pre),
    .start(cmd_fire), .start_read(cmd_read), .start_frame(cmd_frame),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_good(rd_good), .rd_data(rd_data)
  );
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_waddr = '0;
  logic [63:0] csr_wdata = '0;
  logic [5:0]  csr_raddr = '0;
  logic [63:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;
  logic [63:0] cap = '0;
  int          ncap = 0;
  int          n_checks = 0;
  int          n_fail = 0;

  localparam logic [5:0] A_CMD = 6'h00, A_WR = 6'h08, A_RD = 6'h10, A_CFG = 6'h18, A_EN = 6'h20;

  always #2.5 clk = ~clk;

  // pull-up bus model: PHY drives only while the master is released
  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_waddr(csr_waddr),
    .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) if (mdio_oe) begin
    cap = {cap[62:0], mdio_o};
    ncap++;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_waddr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    csr_raddr = a;
    #0.2;
    d = csr_rdata;
  endtask

  task automatic set_cfg(input int div, input bit pre, input bit c45);
    wr(A_CFG, 64'(div) | (64'(pre) << 12) | (64'(c45) << 24));
  endtask

  function automatic logic [63:0] cmd_word(input int opc, input logic [4:0] phy, input logic [4:0] ra);
    return 64'(opc) | (64'(phy) << 8) | (64'(ra) << 16);
  endfunction

  // expected serial frame restated from the requirement text
  function automatic logic [63:0] exp_frame(input bit c45, input int opc, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    logic [1:0] s, o;
    s = c45 ? 2'b00 : 2'b01;
    if (!c45) o = (opc == 0) ? 2'b01 : 2'b10;
    else o = (opc == 0) ? 2'b00 : (opc == 1) ? 2'b01 : 2'b11;
    return {32'hFFFF_FFFF, s, o, phy, ra, 2'b10, d};
  endfunction

  task automatic issue(input int opc, input logic [4:0] phy, input logic [4:0] ra);
    ncap = 0;
    wr(A_CMD, cmd_word(opc, phy, ra));
  endtask

  task automatic wait_idle();
    logic [63:0] a, b;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      rd(A_WR, a); rd(A_RD, b);
      if (!a[16] && !b[17]) break;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic phy_serve(input bit ta2, input logic [15:0] d);
    @(negedge mdio_oe);
    for (int i = 0; i < 17; i++) begin
      @(negedge mdc);
      phy_drv = (i == 0) ? ta2 : d[16-i];
    end
    @(negedge mdc);
    phy_drv = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [63:0] v;
    rd(A_CFG, v); chk("R1", "cfg reset", v, 64'h1004);
    rd(A_EN, v);  chk("R1", "enable reset", v, 0);
    rd(A_WR, v);  chk("R1", "wrdat reset", v, 0);
    rd(A_CMD, v); chk("R1", "cmd reset", v, 0);
    chk("R2", "mdc low when off", mdc, 0);
    chk("R2", "mdio released when off", mdio_oe, 0);
  endtask

  task automatic t_csr_access();
    logic [63:0] v;
    set_cfg(1, 1, 0);
    wr(A_EN, 64'h1);
    wr(A_WR, 64'hA5C3);
    rd(A_CFG, v); chk("R1", "cfg readback", v, 64'h1001);
    rd(A_EN, v);  chk("R1", "enable readback", v, 1);
    rd(A_WR, v);  chk("R1", "wrdat readback", v, 64'hA5C3);
  endtask

  task automatic t_mdc_timing();
    int hi, lo;
    set_cfg(2, 1, 0);
    hi = 0; lo = 0;
    @(negedge clk);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    while (mdc) begin hi++; @(negedge clk); end
    while (!mdc) begin lo++; @(negedge clk); end
    chk("R2", "mdc high cycles", hi, 3);
    chk("R2", "mdc low cycles", lo, 3);
    set_cfg(1, 1, 0);
  endtask

  task automatic t_c22_write();
    logic [63:0] v;
    set_cfg(1, 1, 0);
    wr(A_WR, 64'hBEEF);
    issue(0, 5'h13, 5'h0A);
    rd(A_WR, v); chk("R8", "write busy set", v[16], 1);
    rd(A_RD, v); chk("R8", "read busy clear on write", v[17], 0);
    wait_idle();
    chk("R3", "c22 write bit count", ncap, 64);
    chk("R3", "c22 write frame", cap, exp_frame(0, 0, 5'h13, 5'h0A, 16'hBEEF));
  endtask

  task automatic t_c22_read(input bit ta2, input logic [15:0] d);
    logic [63:0] v;
    set_cfg(1, 1, 0);
    fork
      phy_serve(ta2, d);
      begin
        issue(1, 5'h07, 5'h02);
        rd(A_RD, v); chk("R8", "read busy set", v[17], 1);
        rd(A_WR, v); chk("R8", "write busy clear on read", v[16], 0);
        wait_idle();
      end
    join
    chk("R4", "c22 read header bits", ncap, 46);
    chk("R4", "c22 read header", cap[45:0], exp_frame(0, 1, 5'h07, 5'h02, 16'h0) >> 18);
    rd(A_RD, v);
    if (!ta2) begin
      chk("R4", "c22 read data", v[15:0], d);
      chk("R9", "read good set", v[16], 1);
    end else begin
      chk("R9", "read good clear on bad turnaround", v[16], 0);
    end
  endtask

  task automatic t_good_cleared();
    logic [63:0] v;
    rd(A_RD, v); chk("R9", "good before new command", v[16], 1);
    issue(0, 5'h01, 5'h01);
    rd(A_RD, v); chk("R9", "good cleared by command", v[16], 0);
    wait_idle();
  endtask

  task automatic t_c45_frames();
    logic [63:0] v;
    set_cfg(1, 1, 1);
    wr(A_WR, 64'h1357);
    issue(0, 5'h1F, 5'h03);
    wait_idle();
    chk("R5", "c45 address frame", cap, exp_frame(1, 0, 5'h1F, 5'h03, 16'h1357));
    wr(A_WR, 64'hC0DE);
    issue(1, 5'h1F, 5'h03);
    wait_idle();
    chk("R5", "c45 write frame", cap, exp_frame(1, 1, 5'h1F, 5'h03, 16'hC0DE));
    fork
      phy_serve(0, 16'h8E71);
      begin issue(3, 5'h1F, 5'h03); wait_idle(); end
    join
    chk("R6", "c45 read header", cap[45:0], exp_frame(1, 3, 5'h1F, 5'h03, 16'h0) >> 18);
    rd(A_RD, v);
    chk("R6", "c45 read data", v[15:0], 16'h8E71);
    chk("R6", "c45 read good", v[16], 1);
  endtask

  task automatic t_no_preamble();
    logic [63:0] e;
    set_cfg(1, 0, 0);
    wr(A_WR, 64'h4242);
    issue(0, 5'h0C, 5'h15);
    wait_idle();
    e = exp_frame(0, 0, 5'h0C, 5'h15, 16'h4242);
    chk("R7", "short frame bit count", ncap, 32);
    chk("R7", "short frame bits", cap[31:0], e[31:0]);
    set_cfg(1, 1, 0);
  endtask

  task automatic t_ignored();
    logic [63:0] a, b;
    set_cfg(1, 1, 0);
    issue(2, 5'h01, 5'h01);
    rd(A_WR, a); rd(A_RD, b);
    chk("R10", "c22 opcode 2 ignored", {a[16], b[17]}, 0);
    issue(3, 5'h01, 5'h01);
    rd(A_WR, a); rd(A_RD, b);
    chk("R10", "c22 opcode 3 ignored", {a[16], b[17]}, 0);
    set_cfg(1, 1, 1);
    issue(2, 5'h01, 5'h01);
    rd(A_WR, a); rd(A_RD, b);
    chk("R10", "c45 opcode 2 ignored", {a[16], b[17]}, 0);
    repeat (40) @(negedge clk);
    chk("R10", "no bits driven for ignored commands", ncap, 0);
    set_cfg(1, 1, 0);
    wr(A_EN, 64'h0);
    issue(0, 5'h01, 5'h01);
    rd(A_WR, a);
    chk("R10", "command ignored while disabled", a[16], 0);
    wr(A_EN, 64'h1);
    repeat (10) @(negedge clk);
    rd(A_WR, a);
    chk("R10", "disabled command not replayed", a[16], 0);
  endtask

  task automatic t_collision();
    logic [63:0] a, b;
    bit h1, h2, seen;
    set_cfg(1, 1, 0);
    wr(A_WR, 64'h6001);
    issue(0, 5'h02, 5'h04);
    h1 = 1; h2 = 1; seen = 0;
    fork
      phy_serve(0, 16'h5AA5);
      begin
        for (int k = 0; k < 3000; k++) begin
          @(negedge clk);
          csr_we = 1'b0;
          rd(A_WR, a); rd(A_RD, b);
          if (b[17]) begin seen = 1; break; end
          h2 = h1; h1 = a[16];
          csr_we = 1'b1; csr_waddr = A_CMD; csr_wdata = cmd_word(1, 5'h02, 5'h05);
        end
        csr_we = 1'b0;
        wait_idle();
      end
    join
    chk("R10", "read started after write", seen, 1);
    chk("R10", "command taken in first idle cycle", h1, 0);
    chk("R8", "no gap between busy fall and accept", h2, 1);
    rd(A_RD, a);
    chk("R4", "read after collision data", a[15:0], 16'h5AA5);
    chk("R9", "read after collision good", a[16], 1);
  endtask

  task automatic t_abort();
    logic [63:0] a;
    set_cfg(1, 1, 0);
    issue(0, 5'h03, 5'h03);
    repeat (30) @(negedge clk);
    wr(A_EN, 64'h0);
    @(negedge clk);
    rd(A_WR, a);
    chk("R11", "busy cleared by abort", a[16], 0);
    chk("R11", "mdc low after abort", mdc, 0);
    chk("R11", "mdio released after abort", mdio_oe, 0);
    wr(A_EN, 64'h1);
    wr(A_WR, 64'h0F0F);
    issue(0, 5'h03, 5'h03);
    wait_idle();
    chk("R11", "frame after re-enable", cap, exp_frame(0, 0, 5'h03, 5'h03, 16'h0F0F));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_csr_access();
    t_mdc_timing();
    t_c22_write();
    t_c22_read(0, 16'h1234);
    t_good_cleared();
    t_c22_read(1, 16'hFFFF);
    t_c45_frames();
    t_no_preamble();
    t_ignored();
    t_collision();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule